// File: doc/BRIEF.md
# Receive Byte Queue with Break Insertion

This block sits between a serial receiver and the register file of a UART. It holds up to four received bytes in arrival order. The line side offers bytes over a valid/ready handshake and raises a one-cycle strobe for each detected line break. The bus side always sees the oldest byte on `rd_data`. A one-cycle `rd_pop` strobe, issued when software reads the receive buffer, discards that byte. The block drives the data-available and queue-full status flags, an overrun flag, and a sticky break-change interrupt request.

The command decoder controls the block through single-cycle strobes: receiver enable, receiver disable, receiver reset, error reset and break-interrupt clear. A beat transfers when `in_valid` and `in_ready` are both high at a rising edge. The source must hold `in_valid` and `in_data` until that happens. `in_ready` falls when the queue is full, when the receiver is disabled, and in any cycle that carries a break strobe. A break has priority over data and is never back-pressured. When the queue is full, a break replaces the newest byte with a zero instead of being lost.

Top module: `rxq_top`

## Requirements
- R1: The queue holds exactly four bytes. `fifo_full` is high after the edge at which the occupancy reaches four.
- R2: `rx_rdy` goes high after any byte or break is stored. It stays high until the queue becomes empty.
- R3: `rd_data` shows the oldest stored byte. A `rd_pop` on a non-empty queue removes that byte, exposes the next one in arrival order, and clears `fifo_full`.
- R4: A `brk_evt` strobe stores the byte 0x00 and sets `brk_irq`. `brk_irq` stays high until a `cmd_brk_clr` strobe arrives. If both strobes come in the same cycle, the set wins.
- R5: A break that arrives while four bytes are held overwrites the newest byte with 0x00. The occupancy stays at four and `fifo_full` stays high.
- R6: `in_ready` is high only when three things hold: the receiver is enabled, `fifo_full` is low, and `brk_evt` is low. `cmd_rx_en` enables the receiver, `cmd_rx_dis` disables it, and it is disabled after reset.
- R7: A `cmd_rx_rst` strobe empties the queue and clears `rx_rdy` and `fifo_full`. After it, `rd_data` reads 0x00.
- R8: A `rd_pop` on an empty queue returns 0x00 and changes no flag and no occupancy.
- R9: If `in_valid` is high while the receiver is enabled and the queue is full, the byte is discarded and `overrun` is set. `overrun` stays set until a `cmd_err_clr` strobe. A beat offered while the receiver is disabled is ignored and does not set `overrun`.
- R10: An accepted byte and a `rd_pop` in the same cycle leave the occupancy unchanged and keep arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Received byte offered |
| in_data | input | 8 | Received byte |
| in_ready | output | 1 | Queue accepts a byte this cycle |
| brk_evt | input | 1 | One-cycle line-break event |
| rd_pop | input | 1 | Receive-buffer read strobe (pop) |
| rd_data | output | 8 | Oldest byte, 0x00 when empty |
| rx_rdy | output | 1 | At least one byte held |
| fifo_full | output | 1 | Four bytes held |
| overrun | output | 1 | A byte was lost to a full queue |
| brk_irq | output | 1 | Break-change interrupt request |
| cmd_rx_en | input | 1 | Receiver enable strobe |
| cmd_rx_dis | input | 1 | Receiver disable strobe |
| cmd_rx_rst | input | 1 | Receiver reset strobe |
| cmd_err_clr | input | 1 | Error reset strobe (clears overrun) |
| cmd_brk_clr | input | 1 | Break interrupt clear strobe |

## Verification
The bench fills the queue, pushes a break into the full queue, and pops everything. A design that dropped the break, or wrote it at the head, would return the wrong fourth byte. Such a design might also let the occupancy grow past four. The bench also pops an empty queue, where a wrong design would underflow the count or keep `rx_rdy` high. It issues a simultaneous accept and pop, where a wrong design would lose or reorder a byte. It offers a fifth byte while full, where the byte must not slip in and `overrun` must rise. Finally, it offers a byte while the receiver is disabled, where `overrun` must stay low.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned RXQ_DEPTH = 4;
  localparam int unsigned RXQ_WIDTH = 8;
  localparam int unsigned RXQ_CW    = $clog2(RXQ_DEPTH + 1);
  typedef logic [RXQ_WIDTH-1:0] rxq_byte_t;
  typedef logic [RXQ_CW-1:0]    rxq_cnt_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = RXQ_DEPTH,
  parameter int unsigned W     = RXQ_WIDTH,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          pop,
  input  logic          push,
  input  logic          push_brk,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  head,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_d
);
  logic [W-1:0] mem_q [DEPTH];
  logic [W-1:0] mem_d [DEPTH];
  logic [W-1:0] shf   [DEPTH];
  logic         pop_eff;
  logic         ins;
  logic [W-1:0] ins_byte;
  logic [CW-1:0] cnt_p;

  assign pop_eff  = pop && (cnt_q != '0);
  assign ins      = push || push_brk;
  assign ins_byte = push_brk ? '0 : wdata;
  assign cnt_p    = cnt_q - CW'(pop_eff);

  // shift toward the head on pop; the tail slot refills with zero
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_shift
    if (gi < DEPTH - 1) begin : g_mid
      assign shf[gi] = pop_eff ? mem_q[gi+1] : mem_q[gi];
    end else begin : g_tail
      assign shf[gi] = pop_eff ? '0 : mem_q[gi];
    end
  end

  always_comb begin
    cnt_d = cnt_p;
    for (int i = 0; i < DEPTH; i++) mem_d[i] = shf[i];
    if (flush) begin
      cnt_d = '0;
      for (int i = 0; i < DEPTH; i++) mem_d[i] = '0;
    end else if (ins) begin
      if (cnt_p == CW'(DEPTH)) begin
        mem_d[DEPTH-1] = ins_byte;
      end else begin
        for (int i = 0; i < DEPTH; i++)
          if (CW'(i) == cnt_p) mem_d[i] = ins_byte;
        cnt_d = cnt_p + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign head = (cnt_q != '0) ? mem_q[0] : '0;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R1
  AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && cnt_q != '0 && !ins && !flush) |=> cnt_q == $past(cnt_q) - CW'(1)); // R3
  AST_PUSH_POP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && push && cnt_q != '0 && !flush) |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/rxq_status.sv
module rxq_status
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = RXQ_DEPTH,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_d,
  input  logic          flush,
  input  logic          en_set,
  input  logic          en_clr,
  input  logic          ovr_evt,
  input  logic          ovr_clr,
  input  logic          brk_set,
  input  logic          brk_clr,
  output logic          en_q,
  output logic          rdy_q,
  output logic          full_q,
  output logic          ovr_q,
  output logic          brk_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      rdy_q  <= 1'b0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      brk_q  <= 1'b0;
    end else begin
      if (en_set)      en_q <= 1'b1;
      else if (en_clr) en_q <= 1'b0;
      rdy_q  <= (cnt_d != '0);
      full_q <= (cnt_d == CW'(DEPTH));
      if (ovr_evt)      ovr_q <= 1'b1;
      else if (ovr_clr) ovr_q <= 1'b0;
      if (brk_set)      brk_q <= 1'b1;
      else if (brk_clr) brk_q <= 1'b0;
    end
  end

  AST_BRK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    brk_set |=> brk_q); // R4
  AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!rdy_q && !full_q)); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !ovr_clr) |=> ovr_q); // R9
endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int unsigned DEPTH = RXQ_DEPTH,
  parameter int unsigned W     = RXQ_WIDTH,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  input  logic         brk_evt,
  input  logic         rd_pop,
  output logic [W-1:0] rd_data,
  output logic         rx_rdy,
  output logic         fifo_full,
  output logic         overrun,
  output logic         brk_irq,
  input  logic         cmd_rx_en,
  input  logic         cmd_rx_dis,
  input  logic         cmd_rx_rst,
  input  logic         cmd_err_clr,
  input  logic         cmd_brk_clr
);
  logic          en_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          push;
  logic          ovr_evt;

  assign in_ready = en_q && !fifo_full && !brk_evt;
  assign push     = in_valid && in_ready;
  assign ovr_evt  = in_valid && en_q && fifo_full && !brk_evt;

  rxq_store #(.DEPTH(DEPTH), .W(W)) store_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (cmd_rx_rst),
    .pop      (rd_pop),
    .push     (push),
    .push_brk (brk_evt),
    .wdata    (in_data),
    .head     (rd_data),
    .cnt_q    (cnt_q),
    .cnt_d    (cnt_d)
  );

  rxq_status #(.DEPTH(DEPTH)) status_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_d   (cnt_d),
    .flush   (cmd_rx_rst),
    .en_set  (cmd_rx_en),
    .en_clr  (cmd_rx_dis),
    .ovr_evt (ovr_evt),
    .ovr_clr (cmd_err_clr),
    .brk_set (brk_evt),
    .brk_clr (cmd_brk_clr),
    .en_q    (en_q),
    .rdy_q   (rx_rdy),
    .full_q  (fifo_full),
    .ovr_q   (overrun),
    .brk_q   (brk_irq)
  );

  AST_FULL_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !in_ready); // R6
  AST_EMPTY_HEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_rdy |-> (rd_data == '0)); // R8
  AST_FULL_BRK_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && brk_evt && !rd_pop && !cmd_rx_rst) |=> fifo_full); // R5
  AST_FULL_AT_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> (cnt_q == CW'(DEPTH))); // R1
endmodule

// File: tb/rxq_top_tb.sv
`timescale 1ns/1ps
module rxq_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready;
  logic       brk_evt = 1'b0;
  logic       rd_pop = 1'b0;
  logic [7:0] rd_data;
  logic       rx_rdy, fifo_full, overrun, brk_irq;
  logic       cmd_rx_en = 1'b0, cmd_rx_dis = 1'b0, cmd_rx_rst = 1'b0;
  logic       cmd_err_clr = 1'b0, cmd_brk_clr = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rxq_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .brk_evt(brk_evt), .rd_pop(rd_pop), .rd_data(rd_data),
    .rx_rdy(rx_rdy), .fifo_full(fifo_full), .overrun(overrun), .brk_irq(brk_irq),
    .cmd_rx_en(cmd_rx_en), .cmd_rx_dis(cmd_rx_dis), .cmd_rx_rst(cmd_rx_rst),
    .cmd_err_clr(cmd_err_clr), .cmd_brk_clr(cmd_brk_clr)
  );

  // {valid, data, brk, pop, exp_head, exp_rdy, exp_full}
  localparam int NV = 14;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 8'hA1, 1'b0, 1'b0, 8'hA1, 1'b1, 1'b0},  // R2
    {1'b1, 8'hB2, 1'b0, 1'b0, 8'hA1, 1'b1, 1'b0},
    {1'b1, 8'hC3, 1'b0, 1'b0, 8'hA1, 1'b1, 1'b0},
    {1'b1, 8'hD4, 1'b0, 1'b0, 8'hA1, 1'b1, 1'b1},  // R1
    {1'b0, 8'h00, 1'b0, 1'b1, 8'hB2, 1'b1, 1'b0},  // R3
    {1'b1, 8'hE5, 1'b0, 1'b1, 8'hC3, 1'b1, 1'b0},  // R10
    {1'b0, 8'h00, 1'b0, 1'b1, 8'hD4, 1'b1, 1'b0},
    {1'b0, 8'h00, 1'b0, 1'b1, 8'hE5, 1'b1, 1'b0},
    {1'b0, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0},  // R2 empty
    {1'b0, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0},  // R8
    {1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0},  // R4
    {1'b1, 8'h11, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0},
    {1'b0, 8'h00, 1'b0, 1'b1, 8'h11, 1'b1, 1'b0},
    {1'b0, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push_byte(input logic [7:0] b);
    in_valid = 1'b1; in_data = b;
    step();
    in_valid = 1'b0;
  endtask

  task automatic pop_expect(input string req, input logic [7:0] exp);
    chk(req, rd_data, exp);
    rd_pop = 1'b1;
    step();
    rd_pop = 1'b0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R6 reset in_ready", {7'd0, in_ready}, 8'd0);
    chk("R2 reset rx_rdy", {7'd0, rx_rdy}, 8'd0);
    chk("R1 reset fifo_full", {7'd0, fifo_full}, 8'd0);
    chk("R8 reset rd_data", rd_data, 8'h00);
    // R9: beat while disabled is ignored, no overrun
    in_valid = 1'b1; in_data = 8'h77;
    step();
    in_valid = 1'b0;
    chk("R9 disabled rx_rdy", {7'd0, rx_rdy}, 8'd0);
    chk("R9 disabled overrun", {7'd0, overrun}, 8'd0);
    cmd_rx_en = 1'b1; step(); cmd_rx_en = 1'b0;
    chk("R6 enabled in_ready", {7'd0, in_ready}, 8'd1);
    brk_evt = 1'b1; #0.1;
    chk("R6 break lowers in_ready", {7'd0, in_ready}, 8'd0);
    brk_evt = 1'b0;

    for (int i = 0; i < NV; i++) begin
      in_valid = VEC[i][20]; in_data = VEC[i][19:12];
      brk_evt = VEC[i][11];  rd_pop = VEC[i][10];
      step();
      in_valid = 1'b0; brk_evt = 1'b0; rd_pop = 1'b0;
      chk($sformatf("R3 vec%0d head", i), rd_data, VEC[i][9:2]);
      chk($sformatf("R2 vec%0d rx_rdy", i), {7'd0, rx_rdy}, {7'd0, VEC[i][1]});
      chk($sformatf("R1 vec%0d fifo_full", i), {7'd0, fifo_full}, {7'd0, VEC[i][0]});
    end
    chk("R4 brk_irq sticky", {7'd0, brk_irq}, 8'd1);
    cmd_brk_clr = 1'b1; step(); cmd_brk_clr = 1'b0;
    chk("R4 brk_irq cleared", {7'd0, brk_irq}, 8'd0);

    // R9: overrun on full
    push_byte(8'h21); push_byte(8'h22); push_byte(8'h23); push_byte(8'h24);
    chk("R6 full in_ready", {7'd0, in_ready}, 8'd0);
    in_valid = 1'b1; in_data = 8'h99;
    step();
    in_valid = 1'b0;
    chk("R9 overrun set", {7'd0, overrun}, 8'd1);
    pop_expect("R9 kept 1", 8'h21);
    pop_expect("R9 kept 2", 8'h22);
    pop_expect("R9 kept 3", 8'h23);
    pop_expect("R9 kept 4", 8'h24);
    chk("R9 fifth dropped", {7'd0, rx_rdy}, 8'd0);
    cmd_err_clr = 1'b1; step(); cmd_err_clr = 1'b0;
    chk("R9 overrun cleared", {7'd0, overrun}, 8'd0);

    // R5: break into a full queue
    push_byte(8'h61); push_byte(8'h62); push_byte(8'h63); push_byte(8'h64);
    brk_evt = 1'b1; step(); brk_evt = 1'b0;
    chk("R5 full kept", {7'd0, fifo_full}, 8'd1);
    chk("R5 brk_irq", {7'd0, brk_irq}, 8'd1);
    pop_expect("R5 head", 8'h61);
    chk("R3 pop clears full", {7'd0, fifo_full}, 8'd0);
    pop_expect("R5 second", 8'h62);
    pop_expect("R5 third", 8'h63);
    pop_expect("R5 replaced", 8'h00);
    chk("R5 drained", {7'd0, rx_rdy}, 8'd0);

    // R7: receiver reset
    push_byte(8'h41); push_byte(8'h42); push_byte(8'h43); push_byte(8'h44);
    cmd_rx_rst = 1'b1; step(); cmd_rx_rst = 1'b0;
    chk("R7 rx_rdy", {7'd0, rx_rdy}, 8'd0);
    chk("R7 fifo_full", {7'd0, fifo_full}, 8'd0);
    chk("R7 rd_data", rd_data, 8'h00);
    push_byte(8'h55);
    chk("R7 fresh head", rd_data, 8'h55);

    // R6: disable
    cmd_rx_dis = 1'b1; step(); cmd_rx_dis = 1'b0;
    chk("R6 disabled in_ready", {7'd0, in_ready}, 8'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule